// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Store Queue

This block is a direct-mapped data cache placed between a processor load/store port and a slower memory. Each of its 1024 lines keeps a valid flag, a 20-bit tag and one 32-bit word. Loads that find their word return it one cycle after acceptance. Loads that do not find it hold the requester off while the word is read from memory, written into the line and returned.

Stores never wait for memory. Each store is posted into a four-entry first-in first-out queue, which the memory write port empties in order. A store that hits also updates the cached word, so lines never need a dirty flag. A store that misses does not allocate a line. It clears the valid flag of the line its index selects. A load whose word is still waiting in the queue takes its data from the youngest matching entry and does not read memory, so it never sees a stale value.

The processor side accepts one request at a time with a valid/ready handshake. Memory reads and memory writes each have their own handshake. The queue occupancy is visible on an output.

Top module: `wt_dcache`

## Requirements
- R1: Address bits 11:2 choose the line and bits 31:12 form the tag. Two words with equal bits 11:2 and different tags evict each other, so alternating between them misses every time.
- R2: After reset every line is invalid, the queue is empty, and no memory request or response is active. The first load to any word misses.
- R3: A load whose line is valid with a matching tag raises `cpu_rsp_valid` with the stored word in the cycle after acceptance and issues no memory read.
- R4: On a read miss `cpu_req_ready` stays low until the response. One memory read is issued at the word-aligned address (bits 1:0 zero), held stable until accepted. The returned word is installed and presented in the cycle after `mem_rd_resp_valid`.
- R5: A store that hits writes its data into the line and into the queue. A later load of that word returns the new data without a memory read.
- R6: The queue presents its oldest entry on the memory write port, holds address and data stable until `mem_wr_ready`, drains entries in acceptance order, and reports its occupancy on `wq_count`.
- R7: A store is refused (ready low) only while the queue holds 4 entries. Loads are still accepted while it is full, and the queue never overflows.
- R8: A store that misses installs nothing and invalidates the indexed line. After the queue drains, loads of both the old word and the stored word miss.
- R9: A load whose word address matches a queued store returns the data of the youngest such store in the cycle after acceptance, with no memory read.
- R10: Address bits 1:0 are ignored. Addresses that differ only there use the same line and word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted on this edge when valid |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | Load data valid, one cycle |
| cpu_rsp_rdata | output | 32 | Load data |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Word-aligned read address |
| mem_rd_resp_valid | input | 1 | Read data returned, one cycle |
| mem_rd_resp_data | input | 32 | Read data |
| mem_wr_valid | output | 1 | Queued store offered to memory |
| mem_wr_ready | input | 1 | Memory takes the offered store |
| mem_wr_addr | output | 32 | Word-aligned store address |
| mem_wr_data | output | 32 | Store data |
| wq_count | output | 3 | Entries held in the store queue |

## Verification
The assertions assume memory returns exactly one `mem_rd_resp_valid` pulse per accepted read, and only after the cycle in which the read was accepted. They also assume the requester keeps a request's fields steady while it waits for ready. The bench memory model answers each read once, after a fixed latency. The requester drops valid right after each acceptance. Write-port stalls come only from `mem_wr_ready`, which the bench toggles to fill and drain the queue.

// File: rtl/wtc_pkg.sv
// Shared types for the write-through cache.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package wtc_pkg;
    // Controller phases: idle, read request outstanding, waiting for read data
    typedef enum logic [1:0] {
        CS_IDLE    = 2'd0,
        CS_RD_REQ  = 2'd1,
        CS_RD_WAIT = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/wtc_line_array.sv
// Line storage: one valid flag, tag and data word per line.
// Assumes: fill/store-hit writes and invalidations are never requested for
// the same line in one cycle (the controller issues at most one per cycle).
// Reads are combinational on rd_index.
module wtc_line_array #(
    parameter int INDEX_W = 10,
    parameter int TAG_W   = 20,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_index,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               inval_en,
    input  logic [INDEX_W-1:0] inval_index
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [DATA_W-1:0] data_mem [LINES];

    // Valid flags: cleared at reset, set by writes, cleared by invalidation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (wr_en)    valid_q[wr_index]    <= 1'b1;
            if (inval_en) valid_q[inval_index] <= 1'b0;
        end
    end

    // Tag and data storage: no reset, qualified by the valid flags
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_index]  <= wr_tag;
            data_mem[wr_index] <= wr_data;
        end
    end

    // Combinational read of the addressed line
    always_comb begin
        rd_valid = valid_q[rd_index];
        rd_tag   = tag_mem[rd_index];
        rd_data  = data_mem[rd_index];
    end

    assert_no_write_inval_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && inval_en) |-> (wr_index != inval_index));
endmodule

// File: rtl/wtc_post_queue.sv
// Posted-store FIFO with an associative search for load forwarding.
// Assumes: DEPTH is a power of two of at least 2; push is never raised
// while full; pop only while an entry is present.
module wtc_post_queue #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [ADDR_W-1:0]          push_addr,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic                       head_valid,
    output logic [ADDR_W-1:0]          head_addr,
    output logic [DATA_W-1:0]          head_data,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [ADDR_W-1:0]          find_addr,
    output logic                       find_hit,
    output logic [DATA_W-1:0]          find_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt_q;

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Entry storage, written at the tail
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
        end
    end

    // Head presentation and status
    always_comb begin
        head_valid = (cnt_q != '0);
        head_addr  = addr_q[rd_ptr];
        head_data  = data_q[rd_ptr];
        full       = (cnt_q == CNT_W'(DEPTH));
        count      = cnt_q;
    end

    // Youngest-match search: walk oldest to newest, later matches win
    always_comb begin
        find_hit  = 1'b0;
        find_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if ((CNT_W'(k) < cnt_q) &&
                (addr_q[rd_ptr + PTR_W'(k)] == find_addr)) begin
                find_hit  = 1'b1;
                find_data = data_q[rd_ptr + PTR_W'(k)];
            end
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q != CNT_W'(DEPTH)) || pop);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(cnt_q));
endmodule

// File: rtl/wt_dcache.sv
// Direct-mapped write-through data cache, one word per line, with a posted
// store queue, no-write-allocate and load forwarding from the queue.
// Assumes: memory returns one mem_rd_resp_valid pulse per accepted read;
// requester holds request fields stable while valid and not ready.
module wt_dcache
    import wtc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 10,
    parameter int QDEPTH  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req_valid,
    output logic                        cpu_req_ready,
    input  logic                        cpu_req_we,
    input  logic [ADDR_W-1:0]           cpu_req_addr,
    input  logic [DATA_W-1:0]           cpu_req_wdata,
    output logic                        cpu_rsp_valid,
    output logic [DATA_W-1:0]           cpu_rsp_rdata,
    output logic                        mem_rd_valid,
    input  logic                        mem_rd_ready,
    output logic [ADDR_W-1:0]           mem_rd_addr,
    input  logic                        mem_rd_resp_valid,
    input  logic [DATA_W-1:0]           mem_rd_resp_data,
    output logic                        mem_wr_valid,
    input  logic                        mem_wr_ready,
    output logic [ADDR_W-1:0]           mem_wr_addr,
    output logic [DATA_W-1:0]           mem_wr_data,
    output logic [$clog2(QDEPTH+1)-1:0] wq_count
);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int TAG_W = ADDR_W - INDEX_W - OFF_W;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'((1 << OFF_W) - 1));

    ctl_state_e        state_q;
    logic [ADDR_W-1:0] miss_addr_q;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_data_q;

    logic [ADDR_W-1:0]  req_aligned;
    logic [INDEX_W-1:0] req_index;
    logic [TAG_W-1:0]   req_tag;
    logic               line_valid;
    logic [TAG_W-1:0]   line_tag;
    logic [DATA_W-1:0]  line_data;
    logic               lookup_hit;
    logic               accept, ld_fire, st_fire, fill_done;
    logic               q_full, q_head_valid, fwd_hit;
    logic [ADDR_W-1:0]  q_head_addr, fill_addr;
    logic [DATA_W-1:0]  q_head_data, fwd_data;
    logic               arr_wr_en;
    logic [INDEX_W-1:0] arr_wr_index;
    logic [TAG_W-1:0]   arr_wr_tag;
    logic [DATA_W-1:0]  arr_wr_data;

    // Address split of the incoming request
    always_comb begin
        req_aligned = cpu_req_addr & ALIGN_MASK;
        req_index   = req_aligned[OFF_W +: INDEX_W];
        req_tag     = req_aligned[ADDR_W-1 -: TAG_W];
        fill_addr   = miss_addr_q & ALIGN_MASK;
    end

    // Handshake decode: one request at a time, stores wait only for queue space
    always_comb begin
        cpu_req_ready = (state_q == CS_IDLE) && !(cpu_req_we && q_full);
        accept        = cpu_req_valid && cpu_req_ready;
        ld_fire       = accept && !cpu_req_we;
        st_fire       = accept && cpu_req_we;
        lookup_hit    = line_valid && (line_tag == req_tag);
        fill_done     = (state_q == CS_RD_WAIT) && mem_rd_resp_valid;
    end

    // Line write source: miss fill or store hit (never both in one cycle)
    always_comb begin
        arr_wr_en    = fill_done || (st_fire && lookup_hit);
        arr_wr_index = fill_done ? fill_addr[OFF_W +: INDEX_W] : req_index;
        arr_wr_tag   = fill_done ? fill_addr[ADDR_W-1 -: TAG_W] : req_tag;
        arr_wr_data  = fill_done ? mem_rd_resp_data : cpu_req_wdata;
    end

    wtc_line_array #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W),
        .DATA_W  (DATA_W)
    ) u_lines (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_index    (req_index),
        .rd_valid    (line_valid),
        .rd_tag      (line_tag),
        .rd_data     (line_data),
        .wr_en       (arr_wr_en),
        .wr_index    (arr_wr_index),
        .wr_tag      (arr_wr_tag),
        .wr_data     (arr_wr_data),
        .inval_en    (st_fire && !lookup_hit),
        .inval_index (req_index)
    );

    wtc_post_queue #(
        .DEPTH  (QDEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (st_fire),
        .push_addr  (req_aligned),
        .push_data  (cpu_req_wdata),
        .pop        (q_head_valid && mem_wr_ready),
        .head_valid (q_head_valid),
        .head_addr  (q_head_addr),
        .head_data  (q_head_data),
        .full       (q_full),
        .count      (wq_count),
        .find_addr  (req_aligned),
        .find_hit   (fwd_hit),
        .find_data  (fwd_data)
    );

    // Controller: load lookup, miss request, miss fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= CS_IDLE;
            miss_addr_q <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state_q)
                CS_IDLE: begin
                    if (ld_fire) begin
                        if (fwd_hit) begin
                            rsp_valid_q <= 1'b1;
                            rsp_data_q  <= fwd_data;
                        end else if (lookup_hit) begin
                            rsp_valid_q <= 1'b1;
                            rsp_data_q  <= line_data;
                        end else begin
                            miss_addr_q <= req_aligned;
                            state_q     <= CS_RD_REQ;
                        end
                    end
                end
                CS_RD_REQ: begin
                    if (mem_rd_ready) state_q <= CS_RD_WAIT;
                end
                CS_RD_WAIT: begin
                    if (mem_rd_resp_valid) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= mem_rd_resp_data;
                        state_q     <= CS_IDLE;
                    end
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    // Output drive
    always_comb begin
        cpu_rsp_valid = rsp_valid_q;
        cpu_rsp_rdata = rsp_data_q;
        mem_rd_valid  = (state_q == CS_RD_REQ);
        mem_rd_addr   = fill_addr;
        mem_wr_valid  = q_head_valid;
        mem_wr_addr   = q_head_addr;
        mem_wr_data   = q_head_data;
    end

    assert_fill_blocks_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CS_IDLE) |-> !cpu_req_ready);
    assert_rd_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr));
    assert_hit_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fire && lookup_hit) |=> cpu_rsp_valid && !mem_rd_valid);
    assert_fwd_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fire && fwd_hit) |=> cpu_rsp_valid && (cpu_rsp_rdata == $past(fwd_data)));
    assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));
    assert_store_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_we && q_full) |-> !cpu_req_ready);
endmodule

// File: tb/wt_dcache_bench.sv
module wt_dcache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_data;
    logic        rd_valid, rd_ready = 1'b1;
    logic [31:0] rd_addr;
    logic        resp_valid = 1'b0;
    logic [31:0] resp_data = '0;
    logic        wr_valid, wr_ready = 1'b1;
    logic [31:0] wr_addr, wr_data;
    logic [2:0]  wq_count;

    int n_checks = 0, n_err = 0, rd_cnt = 0;
    logic [31:0] mem_arr [logic [31:0]];
    logic [31:0] gold    [logic [31:0]];
    logic [63:0] exp_q [$];
    logic [63:0] e_ent;
    logic [31:0] lat_addr;

    always #2 clk = ~clk;

    wt_dcache u_wt_dcache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(req_valid), .cpu_req_ready(req_ready), .cpu_req_we(req_we),
        .cpu_req_addr(req_addr), .cpu_req_wdata(req_wdata),
        .cpu_rsp_valid(rsp_valid), .cpu_rsp_rdata(rsp_data),
        .mem_rd_valid(rd_valid), .mem_rd_ready(rd_ready), .mem_rd_addr(rd_addr),
        .mem_rd_resp_valid(resp_valid), .mem_rd_resp_data(resp_data),
        .mem_wr_valid(wr_valid), .mem_wr_ready(wr_ready),
        .mem_wr_addr(wr_addr), .mem_wr_data(wr_data),
        .wq_count(wq_count)
    );

    function automatic logic [31:0] init_word(logic [31:0] a);
        return (a >> 2) * 32'h0100_0193 + 32'h5A5A_1234;
    endfunction
    function automatic logic [31:0] mem_value(logic [31:0] a);
        return mem_arr.exists(a) ? mem_arr[a] : init_word(a);
    endfunction
    function automatic logic [31:0] gold_value(logic [31:0] a);
        return gold.exists(a) ? gold[a] : init_word(a);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    // Memory read model: fixed latency, answers from drained memory contents
    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                lat_addr = rd_addr;
                check(lat_addr[1:0] == 2'b00, "R4 aligned read address", lat_addr, lat_addr & ~32'd3);
                @(posedge clk);
                repeat (3) @(negedge clk);
                resp_data  = mem_value(lat_addr);
                resp_valid = 1'b1;
                @(negedge clk);
                resp_valid = 1'b0;
            end
        end
    end

    // Read counter and in-order drain checker (R6)
    always @(posedge clk) begin
        if (rd_valid && rd_ready) rd_cnt++;
        if (wr_valid && wr_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 drain with nothing queued", wr_addr, 32'h0);
            end else begin
                e_ent = exp_q.pop_front();
                check(wr_addr == e_ent[63:32] && wr_data == e_ent[31:0],
                      "R6 drain order", wr_data, e_ent[31:0]);
                mem_arr[wr_addr] = wr_data;
            end
        end
    end

    // mode: 0 data only, 1 expect hit/forward, 2 expect miss
    task automatic do_load(input logic [31:0] a, input int mode, input string req);
        int r0, cyc;
        bit bad_ready;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        r0 = rd_cnt;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; bad_ready = 1'b0;
        while (!rsp_valid && cyc < 100) begin
            if (req_ready) bad_ready = 1'b1;
            @(negedge clk);
            cyc++;
        end
        check(rsp_valid && rsp_data == gold_value(a & ~32'd3), req, rsp_data,
              gold_value(a & ~32'd3));
        if (mode == 1)
            check(cyc == 1 && rd_cnt == r0, {req, " hit timing, no read"}, cyc, 1);
        if (mode == 2)
            check(rd_cnt == r0 + 1 && !bad_ready && req_ready,
                  {req, " miss: one read, ready low"}, rd_cnt - r0, 1);
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        exp_q.push_back({a & ~32'd3, d});
        gold[a & ~32'd3] = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic wait_drain();
        int guard = 0;
        while (wq_count != 0 && guard < 1000) begin @(negedge clk); guard++; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check(req_ready && wq_count == 0 && !wr_valid && !rd_valid && !rsp_valid,
              "R2 reset state", {27'd0, wq_count, rd_valid, wr_valid}, 0);

        // R2/R4: cold misses over 16 lines, then R3 hits
        for (int i = 0; i < 16; i++) do_load(i * 4, 2, "R2 R4 cold miss");
        for (int i = 0; i < 16; i++) do_load(i * 4, 1, "R3 hit");
        // R10: byte offset ignored
        for (int i = 0; i < 4; i++)
            for (int b = 1; b < 4; b++) do_load(i * 4 + b, 1, "R10 offset ignored");

        // R1: same index, different tag ping-pong
        do_load(32'h1000, 2, "R1 conflict tag 1");
        do_load(32'h0000, 2, "R1 conflict tag 0");
        do_load(32'h1000, 2, "R1 conflict again");
        do_load(32'h1000, 1, "R1 refill hit");

        // R5: store hit updates cache
        do_store(32'h8, 32'hCAFE_0008);
        do_load(32'h8, 1, "R5 store hit load");
        wait_drain();
        do_load(32'h8, 1, "R5 cache updated");

        // R8: store miss invalidates, no allocate
        do_load(32'hC, 1, "R8 line present");
        do_store(32'h100C, 32'hBEEF_100C);
        wait_drain();
        do_load(32'hC, 2, "R8 old line invalidated");
        do_load(32'h100C, 2, "R8 no allocate");

        // R6/R7/R9: saturate the queue
        @(negedge clk); wr_ready = 1'b0;
        do_store(32'h40, 32'h1111_0040);
        do_store(32'h44, 32'h2222_0044);
        do_store(32'h40, 32'h3333_0040);
        do_store(32'h48, 32'h4444_0048);
        check(wq_count == 3'd4 && wr_valid && wr_addr == 32'h40 && wr_data == 32'h1111_0040,
              "R6 count and oldest at head", {29'd0, wq_count}, 4);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = 32'h4C; req_wdata = 32'h5555_004C;
        begin
            bit seen_ready = 1'b0;
            for (int c = 0; c < 4; c++) begin #1; if (req_ready) seen_ready = 1'b1; @(negedge clk); end
            check(!seen_ready, "R7 store refused when full", seen_ready, 0);
        end
        req_valid = 1'b0; req_we = 1'b0;
        do_load(32'h40, 1, "R9 youngest forward");
        do_load(32'h44, 1, "R9 forward second entry");
        check(wq_count == 3'd4, "R7 loads accepted while full", {29'd0, wq_count}, 4);
        @(negedge clk); wr_ready = 1'b1;
        do_store(32'h4C, 32'h5555_004C);
        wait_drain();
        check(exp_q.size() == 0 && wq_count == 0, "R6 all drained", exp_q.size(), 0);
        do_load(32'h44, 2, "R8 store miss not allocated");

        // Mixed sweep with varying write-port stalls
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a;
            a = ((i * 5) % 8) * 4 + ((i * 3) % 2) * 32'h1000 + (i % 4);
            @(negedge clk); wr_ready = (i % 3 != 0);
            if (i % 2 == 0) do_store(a, i * 32'h1111_1111 ^ a);
            else            do_load(a, 0, "R5 R9 mixed sweep");
        end
        @(negedge clk); wr_ready = 1'b1;
        wait_drain();
        for (int i = 0; i < 8; i++) do_load(i * 4 + 32'h1000, 0, "R6 memory after sweep");

        summary();
        $finish;
    end
endmodule